// File: doc/BRIEF.md
# Multiplexed Address/Data Read Sequencer

This block runs read cycles on a 16-bit bus whose pins carry first an address and then data. A request latches a start address, a word count and a small configuration. The block then drives the address while an address-latch strobe is active. It keeps the address on the bus briefly after the strobe ends, releases the bus, and issues read strobes whose low time is programmable. Each word is sampled from the bus as its read strobe rises. The word is returned on `rdata` with a one-cycle `rdata_vld` pulse.

Internally every step is timed by a peripheral clock enable that runs at half the core clock rate. The enable restarts at a fixed phase with each accepted request, so every event lands a known number of core cycles after the request. Two modes are available. In burst mode, one address phase is followed by as many read strobes as the word count asks for. In single mode, each word gets its own address phase, and the address goes up by one each time. An optional hold cycle and an optional flash recovery delay lengthen the gaps between words.

Top module: `madr_read_seq`

## Requirements
- R1: After reset, `ale` is low (inactive), `rd_n` is high, `ad_oe`, `busy` and `rdata_vld` are low.
- R2: A `start` sampled while `busy` is low is accepted and `busy` is high from the next cycle. A `start` sampled while `busy` is high has no effect on the words, addresses or timing of the running transfer.
- R3: The peripheral clock is two core cycles. Each address phase holds `ale` active for 4 core cycles, starting at the accepting edge, with `ad_oe` high and `ad_out` equal to the address. `ale` and the read strobe are never active together.
- R4: The address stays driven for 2 core cycles after `ale` goes inactive. The bus is then released (`ad_oe` low). `rd_n` falls 4 core cycles after `ale` goes inactive and is never low while `ad_oe` is high.
- R5: `rd_n` stays low for 2·D core cycles, where D is `dur_cfg`, and a value of 0 counts as 1.
- R6: Each word is sampled from `ad_in` on the edge where `rd_n` rises, and `rdata_vld` is high for exactly that one cycle. The first word appears 8 + 2·D cycles after the accepting edge.
- R7: In burst mode (`burst_en`=1), N read strobes follow a single address phase and the address is not changed. Consecutive captures are 2·D + 2 + 2·H cycles apart, where H is `hold_en`.
- R8: In single mode (`burst_en`=0), every word has its own address phase, with the address incremented by one modulo 2^16. Captures are 2·D + 10 + 2·H + 14·F cycles apart, where F is `flash_en`.
- R9: `hold_en` adds one peripheral clock (2 core cycles) after every read strobe that is followed by another word.
- R10: `flash_en` adds seven peripheral clocks (14 core cycles) before every address phase after the first, in single mode only.
- R11: `ale_low`=1, latched at acceptance, makes `ale` active low. The inactive level persists while idle after the transfer.
- R12: `busy` falls on the same edge that captures the last word. A `word_count` of 0 transfers one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request |
| start_addr | input | BUS_W | First address |
| word_count | input | WC_W | Number of words (0 means 1) |
| dur_cfg | input | 5 | Read strobe length in peripheral clocks |
| hold_en | input | 1 | Add a hold cycle after each strobe |
| flash_en | input | 1 | Add the flash recovery delay before each later address phase |
| burst_en | input | 1 | 1: all strobes after one address phase; 0: one per address phase |
| ale_low | input | 1 | Address latch strobe active low when set |
| ad_in | input | BUS_W | Bus value seen at the pins |
| ad_out | output | BUS_W | Address driven onto the bus |
| ad_oe | output | 1 | Bus output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| rdata | output | BUS_W | Last captured word |
| rdata_vld | output | 1 | One-cycle pulse with each captured word |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that the configuration inputs matter only on the cycle a request is accepted. They also assume that `ad_in` needs no particular value outside a read strobe, so the bus model may present anything while the block drives the address. The stimulus changes inputs only on falling clock edges and holds `start` for one cycle. Its memory model answers with a value computed from the address it saw latched and from the strobe index. It also retargets a request in the middle of a transfer, so an ignored request would show up as a wrong word, a wrong count or a shifted capture time.

// File: rtl/madr_pkg.sv
package madr_pkg;
  localparam int DUR_W      = 5;
  localparam int ALE_PCLK   = 2;
  localparam int FLASH_PCLK = 7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_AHOLD, PH_TURN, PH_STRB, PH_GAP, PH_HOLD, PH_FLASH
  } phase_t;

  // strobe length in peripheral clocks; a zero field counts as one
  function automatic logic [DUR_W-1:0] strobe_len(input logic [DUR_W-1:0] d);
    return (d == '0) ? DUR_W'(1) : d;
  endfunction
endpackage

// File: rtl/madr_pclk_gen.sv
module madr_pclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph <= 1'b0;
    else if (!run) ph <= 1'b0;
    else          ph <= ~ph;
  end

  assign tick = run & ph;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/madr_phase_ctl.sv
module madr_phase_ctl
  import madr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [DUR_W-1:0] dur_q,
  input  logic             hold_q,
  input  logic             flash_q,
  input  logic             burst_q,
  input  logic             last_word,
  output phase_t           phase,
  output logic             cap,
  output logic             adv
);
  logic [DUR_W-1:0] cnt, nxt_cnt, after_cnt;
  phase_t           nxt_ph, after_ph;

  always_comb begin
    // where to go once the inter-word gap (and hold) is over
    after_ph  = PH_ALE;
    after_cnt = DUR_W'(ALE_PCLK - 1);
    if (burst_q) begin
      after_ph  = PH_STRB;
      after_cnt = strobe_len(dur_q) - DUR_W'(1);
    end else if (flash_q) begin
      after_ph  = PH_FLASH;
      after_cnt = DUR_W'(FLASH_PCLK - 1);
    end
    nxt_ph  = phase;
    nxt_cnt = cnt;
    if (tick) begin
      if (cnt != '0) nxt_cnt = cnt - DUR_W'(1);
      else begin
        unique case (phase)
          PH_ALE:   begin nxt_ph = PH_AHOLD; nxt_cnt = '0; end
          PH_AHOLD: begin nxt_ph = PH_TURN;  nxt_cnt = '0; end
          PH_TURN:  begin nxt_ph = PH_STRB;  nxt_cnt = strobe_len(dur_q) - DUR_W'(1); end
          PH_STRB:  begin nxt_ph = last_word ? PH_IDLE : PH_GAP; nxt_cnt = '0; end
          PH_GAP: begin
            if (hold_q) begin nxt_ph = PH_HOLD; nxt_cnt = '0; end
            else begin nxt_ph = after_ph; nxt_cnt = after_cnt; end
          end
          PH_HOLD:  begin nxt_ph = after_ph; nxt_cnt = after_cnt; end
          PH_FLASH: begin nxt_ph = PH_ALE;   nxt_cnt = DUR_W'(ALE_PCLK - 1); end
          default:  begin nxt_ph = phase;    nxt_cnt = cnt; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (go) begin
      phase <= PH_ALE;
      cnt   <= DUR_W'(ALE_PCLK - 1);
    end else begin
      phase <= nxt_ph;
      cnt   <= nxt_cnt;
    end
  end

  assign cap = tick && (phase == PH_STRB) && (cnt == '0);
  assign adv = tick && (cnt == '0) && (phase != PH_ALE) && (nxt_ph == PH_ALE);

  AST_STROBE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STRB && $past(phase) != PH_STRB) |->
      ($past(phase) == PH_TURN || $past(phase) == PH_GAP || $past(phase) == PH_HOLD)); // R7
  AST_FLASH_SINGLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLASH) |-> !burst_q); // R10
endmodule

// File: rtl/madr_data_path.sv
module madr_data_path #(
  parameter int BUS_W = 16,
  parameter int WC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BUS_W-1:0] start_addr,
  input  logic [WC_W-1:0]  word_count,
  input  logic             cap,
  input  logic             adv,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] addr,
  output logic             last_word,
  output logic [BUS_W-1:0] rdata,
  output logic             rdata_vld
);
  logic [WC_W-1:0] left;

  // words still to go after the first; zero count behaves as one word
  function automatic logic [WC_W-1:0] extra_words(input logic [WC_W-1:0] n);
    return (n == '0) ? '0 : n - WC_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      left      <= '0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= cap;
      if (go) begin
        addr <= start_addr;
        left <= extra_words(word_count);
      end else begin
        if (adv) addr <= addr + BUS_W'(1);
        if (cap && left != '0) left <= left - WC_W'(1);
      end
      if (cap) rdata <= ad_in;
    end
  end

  assign last_word = (left == '0);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |=> !rdata_vld); // R6
endmodule

// File: rtl/madr_read_seq.sv
module madr_read_seq
  import madr_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int WC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BUS_W-1:0] start_addr,
  input  logic [WC_W-1:0]  word_count,
  input  logic [DUR_W-1:0] dur_cfg,
  input  logic             hold_en,
  input  logic             flash_en,
  input  logic             burst_en,
  input  logic             ale_low,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             rd_n,
  output logic [BUS_W-1:0] rdata,
  output logic             rdata_vld,
  output logic             busy
);
  logic [DUR_W-1:0] dur_q;
  logic             hold_q, flash_q, burst_q, pol_q;
  logic             go, tick, cap, adv, last_word;
  logic [BUS_W-1:0] addr;
  phase_t           phase;

  assign busy = (phase != PH_IDLE);
  assign go   = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q   <= '0;
      hold_q  <= 1'b0;
      flash_q <= 1'b0;
      burst_q <= 1'b0;
      pol_q   <= 1'b0;
    end else if (go) begin
      dur_q   <= dur_cfg;
      hold_q  <= hold_en;
      flash_q <= flash_en;
      burst_q <= burst_en;
      pol_q   <= ale_low;
    end
  end

  madr_pclk_gen u_pclk (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  madr_phase_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .dur_q(dur_q), .hold_q(hold_q), .flash_q(flash_q), .burst_q(burst_q),
    .last_word(last_word), .phase(phase), .cap(cap), .adv(adv)
  );

  madr_data_path #(.BUS_W(BUS_W), .WC_W(WC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
    .word_count(word_count), .cap(cap), .adv(adv), .ad_in(ad_in),
    .addr(addr), .last_word(last_word), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  assign ad_oe  = (phase == PH_ALE) || (phase == PH_AHOLD);
  assign ad_out = ad_oe ? addr : '0;
  assign ale    = pol_q ^ (phase == PH_ALE);
  assign rd_n   = (phase != PH_STRB);

  AST_BUS_FREE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R4
  AST_ALE_RD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (ale != pol_q) |-> rd_n); // R3
  AST_BUSY_ENDS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rdata_vld); // R12
endmodule

// File: tb/madr_read_seq_test.sv
`timescale 1ns/1ps
module madr_read_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [3:0]  word_count = '0;
  logic [4:0]  dur_cfg = '0;
  logic        hold_en = 1'b0, flash_en = 1'b0, burst_en = 1'b0, ale_low = 1'b0;
  logic [15:0] ad_in, ad_out, rdata;
  logic        ad_oe, ale, rd_n, rdata_vld, busy;

  int nchk = 0, nfail = 0;
  logic [15:0] lat_a = '0;
  int ridx = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(logic [15:0] a, int i);
    return (a * 16'd37) ^ 16'(i * 257) ^ 16'h5A3C;
  endfunction

  assign ad_in = memf(lat_a, ridx);

  madr_read_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .dur_cfg(dur_cfg), .hold_en(hold_en),
    .flash_en(flash_en), .burst_en(burst_en), .ale_low(ale_low),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n),
    .rdata(rdata), .rdata_vld(rdata_vld), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int d, input int h, input int f, input int b,
                         input int pol, input int wc, input logic [15:0] a0,
                         input bit poke);
    int dd, wtot, first, per, n, words, ale_cnt, rd_cnt, last_t;
    logic [15:0] expd;
    dd    = (d == 0) ? 1 : d;
    wtot  = (wc == 0) ? 1 : wc;
    first = 8 + 2 * dd;
    per   = b ? (2 * dd + 2 + 2 * h) : (2 * dd + 10 + 2 * h + 14 * f);
    @(negedge clk);
    dur_cfg = 5'(d); hold_en = h[0]; flash_en = f[0]; burst_en = b[0];
    ale_low = pol[0]; word_count = 4'(wc); start_addr = a0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; words = 0; ale_cnt = 0; rd_cnt = 0; last_t = 0;
    while (n < 3000) begin
      if (n == 0) chk(ad_oe && ad_out == a0 && ale != pol[0], "R3", int'(ad_out), int'(a0));
      if (n == 4) chk(ad_oe && ale == pol[0], "R4", int'(ad_oe), 1);
      if (n == 6) chk(!ad_oe && rd_n, "R4", int'(ad_oe), 0);
      if (n == 8) chk(!rd_n, "R4", int'(rd_n), 0);
      if (ale != pol[0]) begin
        ale_cnt++;
        if (ad_oe) lat_a = ad_out;
        ridx = 0;
      end
      if (!rd_n) rd_cnt++;
      if (rdata_vld) begin
        if (words == 0) chk(n == first, "R6", n, first);
        else chk(n - last_t == per, (!b && f) ? "R10" : (h ? "R9" : (b ? "R7" : "R8")),
                 n - last_t, per);
        expd = b ? memf(a0, words) : memf(a0 + 16'(words), 0);
        chk(rdata == expd, b ? "R7" : "R8", int'(rdata), int'(expd));
        chk(busy == (words != wtot - 1), "R12", int'(busy), int'(words != wtot - 1));
        last_t = n;
        words++;
        ridx++;
      end
      if (poke && n == 5) begin
        start = 1'b1; start_addr = ~a0; word_count = 4'd9; burst_en = ~b[0];
      end else start = 1'b0;
      if (!busy) break;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(!busy, "R12", int'(busy), 0);
    chk(words == wtot, poke ? "R2" : "R12", words, wtot);
    chk(ale_cnt == 4 * (b ? 1 : wtot), "R3", ale_cnt, 4 * (b ? 1 : wtot));
    chk(rd_cnt == 2 * dd * wtot, "R5", rd_cnt, 2 * dd * wtot);
    @(negedge clk);
    chk(ale == pol[0] && !ad_oe && rd_n, "R11", int'(ale), pol);
  endtask

  initial begin
    int dl[5] = '{0, 1, 2, 5, 31};
    #1;
    chk(ale == 1'b0 && rd_n && !ad_oe && !busy && !rdata_vld, "R1", int'(ale), 0);
    repeat (3) @(negedge clk);
    chk(ale == 1'b0 && rd_n && !ad_oe && !busy && !rdata_vld, "R1", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R2", int'(busy), 0);
    for (int di = 0; di < 5; di++)
      for (int h = 0; h < 2; h++)
        for (int f = 0; f < 2; f++)
          for (int b = 0; b < 2; b++)
            for (int p = 0; p < 2; p++)
              run_txn(dl[di], h, f, b, p, ((di + h + p) % 2 == 1) ? 3 : 1,
                      16'(16'h1234 * (di + 1) + 16'(h * 64 + f * 8 + b * 2 + p)), 1'b0);
    run_txn(2, 0, 0, 0, 0, 0, 16'h00AA, 1'b0);
    run_txn(1, 1, 0, 1, 0, 15, 16'h0F00, 1'b0);
    run_txn(3, 0, 1, 0, 1, 3, 16'hFFFE, 1'b0);
    run_txn(2, 1, 0, 0, 0, 2, 16'h4242, 1'b1);
    run_txn(4, 0, 0, 1, 1, 4, 16'h7777, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule